// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a list of transmit descriptors in system memory on behalf of an Ethernet DMA engine. Once software loads a list base address, the walker reads each descriptor through a simple word-wide memory port. It reads one word per request, and each request is held until the port acknowledges it. If the descriptor is owned by hardware, the walker passes its buffer address and length to a frame-send interface. It then waits for the completion status and closes the descriptor by writing back its first word. That write keeps the software control bits, clears the ownership bit and fills in the status byte. When the descriptor asks for it, the walker also writes a 64-bit transmit timestamp into the descriptor's extension words.

A configuration input selects compact 4-word (16-byte) descriptors or extended 8-word (32-byte) descriptors. Only extended descriptors can hold a timestamp. When the walker meets a descriptor that software still owns, it parks in a suspended state until a poll request arrives. An oversized buffer length is fatal: the walker stops and stays stopped until a reset and a fresh base load.

Descriptor word 0 layout relied upon: bit 31 ownership (1 = hardware), bits 30:18 software control, bit 25 timestamp request, bit 17 timestamp-stored flag, bits 7:0 closing status. Word 1 bits 13:0 hold the byte length and word 2 holds the buffer address. Words 6 and 7 hold the low and high halves of the timestamp.

Top module: `txdesc_walker`

## Requirements
- R1: After each descriptor closes, the next descriptor is fetched at the current address plus 16 bytes when `cfg_wide` is 0, and plus 32 bytes when it is 1.
- R2: With `cfg_wide` at 0, words 4 to 7 of a descriptor are never read or written, no timestamp is stored, and bit 17 of the written-back word 0 is 0.
- R3: Bits 1:0 of `list_base` are ignored. Every memory access uses a word-aligned address.
- R4: The word-0 writeback returns bits 30:18 and 16:8 exactly as fetched and writes bit 31 as 0.
- R5: For an owned descriptor with a valid length, `frm_start` pulses for one cycle with `frm_addr` equal to word 2 and `frm_len` equal to word 1 bits 13:0. The `frm_status` byte presented with `frm_done` lands in word-0 bits 7:0.
- R6: With `cfg_wide` at 1 and word-0 bit 25 set, the `ts_value` sampled at `frm_done` is written to word 6 (bits 31:0) and word 7 (bits 63:32), and bit 17 is written as 1. Otherwise bit 17 is written as 0 and words 6 and 7 are left untouched.
- R7: Timestamp words are written before word 0, in the order word 6, word 7, word 0.
- R8: A descriptor whose length is 0 produces no `frm_start` and is closed with status 8'h01.
- R9: A length above 8192 is fatal: `halted` rises, the descriptor is not written back, and no memory access or frame start follows. Poll requests and base loads are ignored until reset. A length of exactly 8192 is accepted.
- R10: A fetched word 0 with bit 31 clear puts the walker in the suspended state (`suspended` = 1). It stays there until a `poll_kick` pulse makes it fetch the same address again.
- R11: After reset the walker issues no memory access until `base_load` is pulsed, and then it starts at the loaded base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 8-word descriptors, 0 selects 4-word descriptors |
| list_base | input | AW | Byte address of the first descriptor |
| base_load | input | 1 | Pulse: start walking at `list_base` (accepted only while idle) |
| poll_kick | input | 1 | Pulse: re-fetch the current descriptor while suspended |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| frm_start | output | 1 | One-cycle pulse: a frame may be sent |
| frm_addr | output | 32 | Buffer address of the frame |
| frm_len | output | 14 | Frame length in bytes |
| frm_done | input | 1 | Pulse: the frame has completed |
| frm_status | input | 8 | Completion status, valid with `frm_done` |
| ts_value | input | 64 | Captured transmit time, sampled with `frm_done` |
| suspended | output | 1 | Walker is parked on a descriptor that software owns |
| halted | output | 1 | Walker stopped on a fatal length error |

## Verification
The fatal-length halt is the hardest state to reach, because it ends the walk and must be shown to freeze every later access. The stimulus reaches it last. The bench first walks a ring to a software-owned descriptor, then rewrites that descriptor with an oversized length and uses a poll request to make the walker fetch it. After that, further poll requests and base loads are applied while the bench counts memory accesses and checks that the descriptor's ownership bit still reads as set. The write order of the timestamp words is checked from a log of every write the memory model accepts.

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int AW      = 32,
  parameter int MAX_LEN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic [AW-1:0] list_base,
  input  logic          base_load,
  input  logic          poll_kick,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          frm_start,
  output logic [31:0]   frm_addr,
  output logic [13:0]   frm_len,
  input  logic          frm_done,
  input  logic [7:0]    frm_status,
  input  logic [63:0]   ts_value,
  output logic          suspended,
  output logic          halted
);
  localparam logic [3:0] S_IDLE = 4'd0, S_RD0 = 4'd1, S_RD1 = 4'd2, S_RD2 = 4'd3,
                         S_CHK  = 4'd4, S_SEND = 4'd5, S_WAIT = 4'd6, S_WR6 = 4'd7,
                         S_WR7  = 4'd8, S_WR0 = 4'd9, S_SUSP = 4'd10, S_HALT = 4'd11;
  localparam logic [7:0] ZLEN_STATUS = 8'h01;

  logic [3:0]    state;
  logic [AW-1:0] cur;
  logic [31:0]   w0, bufa;
  logic [13:0]   len;
  logic [7:0]    st;
  logic [63:0]   ts;
  logic          ts_do;
  logic [2:0]    woff;

  always_comb begin
    case (state)
      S_RD1:   woff = 3'd1;
      S_RD2:   woff = 3'd2;
      S_WR6:   woff = 3'd6;
      S_WR7:   woff = 3'd7;
      default: woff = 3'd0;
    endcase
  end

  assign mem_req   = (state == S_RD0) || (state == S_RD1) || (state == S_RD2) ||
                     (state == S_WR6) || (state == S_WR7) || (state == S_WR0);
  assign mem_we    = (state == S_WR6) || (state == S_WR7) || (state == S_WR0);
  assign mem_addr  = cur + AW'({woff, 2'b00});
  assign mem_wdata = (state == S_WR6) ? ts[31:0] :
                     (state == S_WR7) ? ts[63:32] :
                     {1'b0, w0[30:18], ts_do, w0[16:8], st};
  assign frm_start = (state == S_SEND);
  assign frm_addr  = bufa;
  assign frm_len   = len;
  assign suspended = (state == S_SUSP);
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      w0    <= '0;
      bufa  <= '0;
      len   <= '0;
      st    <= '0;
      ts    <= '0;
      ts_do <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (base_load) begin
          cur   <= {list_base[AW-1:2], 2'b00};
          state <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          w0    <= mem_rdata;
          state <= mem_rdata[31] ? S_RD1 : S_SUSP;
        end
        S_RD1: if (mem_ack) begin
          len   <= mem_rdata[13:0];
          state <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          bufa  <= mem_rdata;
          state <= S_CHK;
        end
        S_CHK: begin
          if (len == 14'd0) begin
            st    <= ZLEN_STATUS;
            ts_do <= 1'b0;
            state <= S_WR0;
          end else if (int'(len) > MAX_LEN) begin
            state <= S_HALT;
          end else begin
            state <= S_SEND;
          end
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: if (frm_done) begin
          st    <= frm_status;
          ts    <= ts_value;
          ts_do <= w0[25] & cfg_wide;
          state <= (w0[25] & cfg_wide) ? S_WR6 : S_WR0;
        end
        S_WR6: if (mem_ack) state <= S_WR7;
        S_WR7: if (mem_ack) state <= S_WR0;
        S_WR0: if (mem_ack) begin
          cur   <= cur + (cfg_wide ? AW'(32) : AW'(16));
          state <= S_RD0;
        end
        S_SUSP: if (poll_kick) state <= S_RD0;
        S_HALT: state <= S_HALT;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module txdesc_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wide,
  input logic          poll_kick,
  input logic [3:0]    state,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          frm_start,
  input logic          suspended,
  input logic          halted
);
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !frm_start));
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r4_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state == 4'd9) |-> !mem_wdata[31]);
  a_r2_narrow_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !cfg_wide) |-> (state != 4'd7 && state != 4'd8));
  a_r10_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !poll_kick) |=> suspended);
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !frm_start);
endmodule

bind txdesc_walker txdesc_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .poll_kick(poll_kick),
  .state(state), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .frm_start(frm_start), .suspended(suspended),
  .halted(halted)
);

// File: tb/test_txdesc_walker.sv
module test_txdesc_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [31:0] list_base = '0;
  logic        base_load = 1'b0, poll_kick = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        frm_start, frm_done = 1'b0;
  logic [31:0] frm_addr;
  logic [13:0] frm_len;
  logic [7:0]  frm_status = '0;
  logic [63:0] ts_value = '0;
  logic        suspended, halted;

  int checks = 0, fails = 0, accesses = 0;
  logic [31:0] mem [64];
  logic [31:0] wlog [$];
  logic [31:0] q_addr [$];
  logic [13:0] q_len [$];
  logic [7:0]  q_st [$];

  always #5 clk = ~clk;

  txdesc_walker i_txdesc_walker (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      accesses++;
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata;
        wlog.push_back(mem_addr);
      end else mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (frm_start) begin
        if (q_addr.size() == 0) chk("R5 unexpected frame", 1, 0);
        else begin
          chk("R5 frame addr", frm_addr, q_addr.pop_front());
          chk("R5 frame len", frm_len, q_len.pop_front());
          repeat (3) @(negedge clk);
          frm_status = q_st.pop_front();
          frm_done = 1'b1;
          @(negedge clk);
          frm_done = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic put_desc(input int idx, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic exp_frame, input logic [7:0] s);
    mem[idx] = w0; mem[idx+1] = w1; mem[idx+2] = w2;
    if (exp_frame) begin
      q_addr.push_back(w2); q_len.push_back(w1[13:0]); q_st.push_back(s);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_susp();
    int n = 0;
    while (suspended && n < 50) begin @(negedge clk); n++; end
    while (!suspended && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] closed(input logic [31:0] w0, input logic ts, input logic [7:0] s);
    return (w0 & ~32'h8002_00FF) | (ts ? 32'h0002_0000 : 32'h0) | {24'h0, s};
  endfunction

  initial begin
    int a0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (3) @(negedge clk);
    chk("R11 reset mem_req", mem_req, 0);
    chk("R11 reset frm_start", frm_start, 0);
    chk("R10 reset suspended", suspended, 0);
    chk("R9 reset halted", halted, 0);
    rst_n = 1'b1;

    put_desc(0,  32'hC2A6_3300, 32'd100, 32'h1000_0000, 1, 8'h5A);
    put_desc(4,  32'h8000_0000, 32'd8192, 32'h2000_0040, 1, 8'h00);
    put_desc(8,  32'h0000_0000, 32'd50, 32'h3000_0000, 0, 8'h00);
    repeat (10) @(negedge clk);
    chk("R11 idle before base_load", accesses, 0);
    list_base = 32'h0000_0003;
    pulse(base_load);
    wait_susp();
    chk("R10 suspended on unowned", suspended, 1);
    chk("R4 R2 narrow writeback desc0", mem[0], closed(32'hC2A6_3300, 0, 8'h5A));
    chk("R1 R9 narrow stride, 8192 accepted", mem[4], closed(32'h8000_0000, 0, 8'h00));
    chk("R2 word3 untouched", mem[3], 32'hDEAD_0003);
    chk("R2 word7 untouched", mem[7], 32'hDEAD_0007);
    chk("R3 R7 narrow write order", {wlog[0], wlog[1]}, {32'h0, 32'h10});
    a0 = accesses;
    repeat (20) @(negedge clk);
    chk("R10 holds without poll", suspended, 1);
    chk("R10 no refetch without poll", accesses, a0);

    put_desc(8, 32'h8010_0000, 32'd0, 32'h3000_0000, 0, 8'h00);
    put_desc(12, 32'h0, 32'd0, 32'h0, 0, 8'h00);
    pulse(poll_kick);
    wait_susp();
    chk("R8 zero length closed", mem[8], closed(32'h8010_0000, 0, 8'h01));
    chk("R8 no frame queued left", q_addr.size(), 0);

    cfg_wide = 1'b1;
    do_reset();
    wlog.delete();
    for (int i = 0; i < 64; i++) mem[i] = 32'hBEEF_0000 + i;
    put_desc(16, 32'h8200_0000, 32'd64, 32'h4000_0000, 1, 8'h21);
    put_desc(24, 32'h8002_0000, 32'd1500, 32'h5000_0000, 1, 8'h03);
    put_desc(32, 32'h0, 32'd0, 32'h0, 0, 8'h00);
    ts_value = 64'h1122_3344_5566_7788;
    list_base = 32'h40;
    pulse(base_load);
    wait_susp();
    chk("R6 ts low word", mem[22], 32'h5566_7788);
    chk("R6 ts high word", mem[23], 32'h1122_3344);
    chk("R6 R4 ts flag set", mem[16], closed(32'h8200_0000, 1, 8'h21));
    chk("R6 bit17 cleared no request", mem[24], closed(32'h8002_0000, 0, 8'h03));
    chk("R6 words6/7 untouched", {mem[30], mem[31]}, {32'hBEEF_001E, 32'hBEEF_001F});
    chk("R7 write count", wlog.size(), 4);
    chk("R7 R1 write order", {wlog[0], wlog[1], wlog[2], wlog[3]},
        {32'h58, 32'h5C, 32'h40, 32'h60});

    put_desc(32, 32'h8000_0000, 32'd8193, 32'h6000_0000, 0, 8'h00);
    pulse(poll_kick);
    repeat (20) @(negedge clk);
    chk("R9 halted on oversize", halted, 1);
    chk("R9 no writeback", mem[32], 32'h8000_0000);
    a0 = accesses;
    pulse(poll_kick);
    pulse(base_load);
    repeat (10) @(negedge clk);
    chk("R9 inputs ignored when halted", {halted, 32'(accesses)}, {1'b1, 32'(a0)});
    do_reset();
    chk("R9 reset clears halt", halted, 0);
    chk("R11 idle after reset", mem_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule